// File: doc/BRIEF.md
# Cascaded Down/Up Timer Pair

The block is a two-counter time base for a peripheral bus. A fine counter, 15 bits wide, counts down by one on every prescaler tick. When a tick finds it at zero it reloads to its all-ones value. That reload is an underflow. Each underflow advances a coarse 16-bit up-counter by one. Software can therefore read a coarse time in underflow periods and a fine sub-count within the current period.

Both counters can be written from the bus. A write takes effect at the next clock edge and takes priority over any count that edge would have made. Every underflow also raises a single-cycle interrupt-request pulse, which can be used as a periodic event. Both counter values are always visible at the outputs for reading.

Top module: `casc_timer`

## Requirements
- R1: After reset the down-counter reads 0x0000, the up-counter reads 0x0000 and the interrupt pulse is low.
- R2: A tick occurs once every TICK_DIV (default 16) system clocks. The first tick comes at the TICK_DIV-th rising edge after reset is released. On a tick with a non-zero value, the down-counter decrements by exactly one. Between ticks it holds its value.
- R3: On a tick with the down-counter at zero, the down-counter reloads to 0x7FFF. This is an underflow.
- R4: Each underflow increments the up-counter by exactly one.
- R5: The up-counter wraps from 0xFFFF to 0x0000 on an underflow.
- R6: The edge that makes an underflow also sets irqPulse high. irqPulse stays high for exactly that one clock cycle.
- R7: A down-counter write (wrEn=1, wrSel=0) loads wrData[14:0] at the next edge. Bit 15 of wrData is ignored, and downVal[15] always reads 0.
- R8: An up-counter write (wrEn=1, wrSel=1) loads all 16 bits of wrData at the next edge.
- R9: A down-counter write in a tick cycle overrides the count. No underflow happens: the up-counter is unchanged and no pulse is produced, even when the down-counter was zero.
- R10: An up-counter write in an underflow cycle overrides the increment. The down-counter still reloads and the pulse is still produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe |
| wrSel | input | 1 | Write target: 0 down-counter, 1 up-counter |
| wrData | input | 16 | Write data |
| downVal | output | 16 | Down-counter value, bit 15 zero |
| upVal | output | 16 | Up-counter value |
| irqPulse | output | 1 | One-cycle underflow interrupt request |

## Verification
The collision of interest is a bus write that lands in the same cycle as a tick, especially a tick that would underflow. The bench follows the prescaler phase, loads the down-counter with zero, and issues the write in the tick cycle itself. It then judges R9 and R10 by whether the up-counter moved and whether the pulse appeared. Random write traffic also drives such collisions at arbitrary phases. Every cycle of that traffic is compared against a reference model built from the requirements.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
  typedef struct packed {
    logic loadDown;
    logic loadUp;
    logic stepDown;
    logic wrapDown;
    logic stepUp;
  } tmrStrobe_t;
endpackage

// File: rtl/ctimer_ctrl.sv
module ctimer_ctrl
  import ctimer_pkg::*;
#(
  parameter int TICK_DIV = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic       downZero,
  output tmrStrobe_t strb,
  output logic       tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV > 1) begin : g_presc
      logic [PW-1:0] presc;
      always_ff @(posedge clk) begin
        if (!rstN) presc <= '0;
        else if (presc == PW'(TICK_DIV - 1)) presc <= '0;
        else presc <= presc + 1'b1;
      end
      assign tick = (presc == PW'(TICK_DIV - 1));
    end else begin : g_noPresc
      assign tick = 1'b1;
    end
  endgenerate

  always_comb begin
    strb.loadDown = wrEn && !wrSel;
    strb.loadUp   = wrEn && wrSel;
    strb.stepDown = tick && !strb.loadDown && !downZero;
    strb.wrapDown = tick && !strb.loadDown && downZero;
    strb.stepUp   = strb.wrapDown && !strb.loadUp;
  end

  generate
    if (TICK_DIV > 1) begin : g_tickChk
      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate

  // R9
  write_beats_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |-> !(strb.wrapDown || strb.stepDown));
endmodule

// File: rtl/ctimer_dp.sv
module ctimer_dp
  import ctimer_pkg::*;
#(
  parameter int DOWN_W = 15,
  parameter int UP_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strb,
  input  logic [UP_W-1:0]   wrData,
  output logic [DOWN_W-1:0] downCnt,
  output logic [UP_W-1:0]   upCnt,
  output logic              downZero,
  output logic              irqPulse
);
  localparam logic [DOWN_W-1:0] RELOAD = {DOWN_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) downCnt <= '0;
    else if (strb.loadDown) downCnt <= wrData[DOWN_W-1:0];
    else if (strb.wrapDown) downCnt <= RELOAD;
    else if (strb.stepDown) downCnt <= downCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) upCnt <= '0;
    else if (strb.loadUp) upCnt <= wrData;
    else if (strb.stepUp) upCnt <= upCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqPulse <= 1'b0;
    else irqPulse <= strb.wrapDown;
  end

  assign downZero = (downCnt == '0);

  // R2
  down_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepDown |=> downCnt == DOWN_W'($past(downCnt) - 1'b1));

  // R3
  reload_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> downCnt == RELOAD);

  // R4
  up_increment_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepUp |=> upCnt == UP_W'($past(upCnt) + 1'b1));

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);
endmodule

// File: rtl/casc_timer.sv
module casc_timer
  import ctimer_pkg::*;
#(
  parameter int TICK_DIV = 16,
  parameter int DOWN_W   = 15,
  parameter int UP_W     = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            wrSel,
  input  logic [UP_W-1:0] wrData,
  output logic [UP_W-1:0] downVal,
  output logic [UP_W-1:0] upVal,
  output logic            irqPulse
);
  tmrStrobe_t        strb;
  logic              tick;
  logic              downZero;
  logic [DOWN_W-1:0] downCnt;

  ctimer_ctrl #(.TICK_DIV(TICK_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .downZero(downZero), .strb(strb), .tick(tick)
  );

  ctimer_dp #(.DOWN_W(DOWN_W), .UP_W(UP_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .downCnt(downCnt), .upCnt(upVal), .downZero(downZero), .irqPulse(irqPulse)
  );

  assign downVal = UP_W'(downCnt);

  // R7
  top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    downVal[UP_W-1] == 1'b0);
endmodule

// File: tb/casc_timer_test.sv
module casc_timer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] downVal, upVal;
  logic irqPulse;

  int tests = 0;
  int fails = 0;

  logic [3:0]  mPresc = '0;
  logic [14:0] mDown = '0;
  logic [15:0] mUp = '0;
  logic        mIrq = 1'b0;

  always #10 clk = ~clk;

  casc_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .downVal(downVal), .upVal(upVal), .irqPulse(irqPulse)
  );

  function automatic logic [14:0] nextDown(logic [3:0] p, logic [14:0] d,
                                           logic we, logic sel, logic [15:0] wd);
    if (we && !sel) return wd[14:0];
    if (p == 4'd15) return (d == 0) ? 15'h7FFF : d - 1'b1;
    return d;
  endfunction

  function automatic logic isWrap(logic [3:0] p, logic [14:0] d, logic we, logic sel);
    return (p == 4'd15) && (d == 0) && !(we && !sel);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic we, logic sel, logic [15:0] wd, string req);
    logic w;
    wrEn = we; wrSel = sel; wrData = wd;
    @(posedge clk);
    w = isWrap(mPresc, mDown, we, sel);
    mDown = nextDown(mPresc, mDown, we, sel, wd);
    if (we && sel) mUp = wd;
    else if (w) mUp = mUp + 1'b1;
    mIrq = w;
    mPresc = mPresc + 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check({req, " down"}, downVal, {1'b0, mDown});
    check({req, " up"}, upVal, mUp);
    check({req, " irq"}, {15'b0, irqPulse}, {15'b0, mIrq});
  endtask

  task automatic idleTo(logic [3:0] p);
    while (mPresc != p) step(1'b0, 1'b0, 16'h0, "R2");
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1F2E;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 down", downVal, 16'h0000);
    check("R1 up", upVal, 16'h0000);
    check("R1 irq", {15'b0, irqPulse}, 16'h0);

    // first tick underflows from zero: R3 R4 R6
    idleTo(4'd15);
    step(1'b0, 1'b0, 16'h0, "R3");
    check("R3 reload", downVal, 16'h7FFF);
    check("R4 cascade", upVal, 16'h0001);
    check("R6 pulse high", {15'b0, irqPulse}, 16'h1);
    step(1'b0, 1'b0, 16'h0, "R6");
    check("R6 pulse one cycle", {15'b0, irqPulse}, 16'h0);

    // R7 bit 15 ignored
    step(1'b1, 1'b0, 16'hFFFF, "R7");
    check("R7 mask", downVal, 16'h7FFF);
    step(1'b1, 1'b0, 16'h8005, "R7");
    check("R7 load", downVal, 16'h0005);

    // R2 hold between ticks, then single decrement
    idleTo(4'd14);
    check("R2 hold", downVal, 16'h0005);
    step(1'b0, 1'b0, 16'h0, "R2");
    step(1'b0, 1'b0, 16'h0, "R2");
    check("R2 decrement", downVal, 16'h0004);

    // R8 and R5 wrap
    step(1'b1, 1'b1, 16'hFFFF, "R8");
    check("R8 load", upVal, 16'hFFFF);
    step(1'b1, 1'b0, 16'h0000, "R5");
    idleTo(4'd15);
    step(1'b0, 1'b0, 16'h0, "R5");
    check("R5 wrap", upVal, 16'h0000);

    // R9 down write in an underflow cycle
    step(1'b1, 1'b0, 16'h0000, "R9");
    idleTo(4'd15);
    step(1'b1, 1'b0, 16'h0123, "R9");
    check("R9 down", downVal, 16'h0123);
    check("R9 up kept", upVal, 16'h0000);
    check("R9 no pulse", {15'b0, irqPulse}, 16'h0);

    // R10 up write in an underflow cycle
    step(1'b1, 1'b0, 16'h0000, "R10");
    idleTo(4'd15);
    step(1'b1, 1'b1, 16'h4444, "R10");
    check("R10 up", upVal, 16'h4444);
    check("R10 reload", downVal, 16'h7FFF);
    check("R10 pulse", {15'b0, irqPulse}, 16'h1);

    // random traffic against the model, R4 cascade over many periods
    for (int i = 0; i < 6000; i++) begin
      logic we, sel;
      logic [15:0] d;
      we = ($urandom % 8) == 0;
      sel = $urandom % 2;
      d = sel ? 16'($urandom) : 16'($urandom % 4) | (16'($urandom % 2) << 15);
      step(we, sel, d, "R4 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule